// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flag

This block is a 256-word by 18-bit first-in, first-out buffer whose write side and read side run on separate clocks. The two clocks may be unrelated or may be one and the same. A write takes place on a rising write-clock edge with `wr_en` high. A read takes place on a rising read-clock edge with `rd_en` high. The oldest stored word is always presented on the read data port without waiting for a read edge, so a read edge takes that word away and shows the next one.

Four flags report the fill level. Two are active low: `full_n` and `empty_n`. Two are active high: `half_full`, and `near_edge`, which is set when the buffer is nearly empty or nearly full. The two `near_edge` thresholds can be loaded from the low byte of the write data in a short window after reset while `prog_n` is held low. These loading edges store nothing in the buffer. The read data port floats to high impedance while `out_en_n` is high.

Top module: `dcfifo_thresh`

## Requirements
- R1: The buffer holds up to 256 words and returns them in write order. A write edge while 256 words are stored leaves the stored words unchanged. A read edge while empty changes nothing.
- R2: `full_n` is 0 exactly when 256 words are stored, and `empty_n` is 0 exactly when none are stored. Each flag settles within three edges of the opposite clock after that clock's last pointer change.
- R3: `half_full` is 1 when 128 or more words are stored and 0 when 127 or fewer are stored.
- R4: `near_edge` is 1 when the count is at most LO or at least 256 − HI, and 0 for counts from LO+1 to 255−HI.
- R5: An asynchronous low level on `rst_n` empties the buffer and sets `full_n`=1, `empty_n`=0, `half_full`=0 and `near_edge`=1.
- R6: After reset, the first write edge with `prog_n`=0 loads `wr_data[7:0]` into both LO and HI. If the next write edge also has `prog_n`=0, it loads `wr_data[7:0]` into HI only. Neither of these edges stores a word.
- R7: A loaded threshold above 127 is taken as 127. Without loading, LO and HI both equal the parameter `DEF_OFFSET` (default 32).
- R8: The loading window closes for good at the first write edge with `prog_n`=1, and that edge stores its word. It also closes after the second loading edge. Once it is closed, `prog_n` has no effect until the next reset.
- R9: The first word written into an empty buffer appears on `rd_data` as `empty_n` rises, with no read edge.
- R10: While `out_en_n` is 1, every bit of `rd_data` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Qualifies a write-clock edge as a write or loading edge |
| prog_n | input | 1 | Threshold loading request, active low |
| wr_data | input | 18 | Write data; bits 7:0 carry threshold values while loading |
| rd_en | input | 1 | Qualifies a read-clock edge as a read |
| out_en_n | input | 1 | Read data drive enable, active low |
| rd_data | output | 18 | Oldest stored word, or high impedance |
| full_n | output | 1 | Low when 256 words are stored |
| empty_n | output | 1 | Low when no word is stored |
| half_full | output | 1 | High at 128 or more words |
| near_edge | output | 1 | High when the count is within a threshold of empty or full |

## Verification
A write pointer that moves on a refused write would show up later as a stray word in the read order, or as a flag that goes wrong once the buffer is drained. So the bench fills the buffer to capacity, drains it completely, and compares every word. A lost or duplicated pointer update appears within three clock edges as a wrong flag at the checked fill levels. These levels sit on either side of every threshold. A faulty loading sequence shows up in two ways: `near_edge` toggles at the wrong count, or a loading edge leaves a word behind, so `empty_n` rises a few edges later.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;

  // State of the post-reset threshold loading window
  typedef enum logic [1:0] {
    PW_FIRST  = 2'd0,
    PW_SECOND = 2'd1,
    PW_CLOSED = 2'd2
  } prog_win_e;

endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Unregistered read port gives first-word fall-through
  assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
  import fifo_thr_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DEF_OFFSET = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          prog_n,
  input  logic [AW-1:0] din_low,
  input  logic [AW:0]   rgray_sync,
  output logic [AW:0]   wptr,
  output logic [AW:0]   wgray,
  output logic          store_we,
  output logic          prog_edge,
  output logic          full_n,
  output logic          half_full,
  output logic          near_edge,
  output logic [AW-1:0] thr_lo,
  output logic [AW-1:0] thr_hi,
  output prog_win_e     win
);

  localparam int          DEPTH   = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_V  = (AW+1)'(DEPTH / 2);
  localparam logic [AW-1:0] OFF_MAX = AW'(DEPTH / 2 - 1);
  localparam logic [AW-1:0] OFF_DEF = AW'(DEF_OFFSET);

  function automatic logic [AW:0] bin2gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW-1:0] clamp_off(input logic [AW-1:0] v);
    return (v > OFF_MAX) ? OFF_MAX : v;
  endfunction

  logic [AW:0] rptr_seen;
  logic [AW:0] fill;
  logic        is_full;

  assign rptr_seen = gray2bin(rgray_sync);
  assign fill      = wptr - rptr_seen;
  assign is_full   = (fill == DEPTH_V);

  assign prog_edge = wr_en && !prog_n && (win != PW_CLOSED);
  assign store_we  = wr_en && !prog_edge && !is_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      wgray  <= '0;
      win    <= PW_FIRST;
      thr_lo <= OFF_DEF;
      thr_hi <= OFF_DEF;
    end else begin
      if (wr_en) begin
        unique case (win)
          PW_FIRST: begin
            if (!prog_n) begin
              thr_lo <= clamp_off(din_low);
              thr_hi <= clamp_off(din_low);
              win    <= PW_SECOND;
            end else begin
              win <= PW_CLOSED;
            end
          end
          PW_SECOND: begin
            if (!prog_n) thr_hi <= clamp_off(din_low);
            win <= PW_CLOSED;
          end
          default: win <= PW_CLOSED;
        endcase
      end
      if (store_we) begin
        wptr  <= wptr + 1'b1;
        wgray <= bin2gray(wptr + 1'b1);
      end
    end
  end

  assign full_n    = !is_full;
  assign half_full = (fill >= HALF_V);
  assign near_edge = (fill <= {1'b0, thr_lo}) ||
                     (fill >= (DEPTH_V - {1'b0, thr_hi}));

endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side #(
  parameter int AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [AW:0] wgray_sync,
  output logic [AW:0] rptr,
  output logic [AW:0] rgray,
  output logic        rd_accept,
  output logic        empty_n
);

  function automatic logic [AW:0] bin2gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  assign empty_n   = (rgray != wgray_sync);
  assign rd_accept = rd_en && empty_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
    end else if (rd_accept) begin
      rptr  <= rptr + 1'b1;
      rgray <= bin2gray(rptr + 1'b1);
    end
  end

endmodule

// File: rtl/dcfifo_thresh.sv
module dcfifo_thresh
  import fifo_thr_pkg::*;
#(
  parameter int DW         = 18,
  parameter int AW         = 8,
  parameter int DEF_OFFSET = 32
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          prog_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_full,
  output logic          near_edge
);

  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr, wr_gray, wr_gray_rd;
  logic [PW-1:0] rd_ptr, rd_gray, rd_gray_wr;
  logic          store_we, prog_edge, rd_accept;
  logic [AW-1:0] thr_lo, thr_hi;
  prog_win_e     win;
  logic [DW-1:0] head_word;

  fifo_wr_side #(.AW(AW), .DEF_OFFSET(DEF_OFFSET)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .prog_n(prog_n),
    .din_low(wr_data[AW-1:0]), .rgray_sync(rd_gray_wr),
    .wptr(wr_ptr), .wgray(wr_gray), .store_we(store_we),
    .prog_edge(prog_edge), .full_n(full_n), .half_full(half_full),
    .near_edge(near_edge), .thr_lo(thr_lo), .thr_hi(thr_hi), .win(win)
  );

  fifo_rd_side #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .wgray_sync(wr_gray_rd),
    .rptr(rd_ptr), .rgray(rd_gray), .rd_accept(rd_accept), .empty_n(empty_n)
  );

  fifo_gray_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_rd)
  );

  fifo_gray_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_wr)
  );

  fifo_store #(.DW(DW), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(store_we), .waddr(wr_ptr[AW-1:0]), .wdata(wr_data),
    .raddr(rd_ptr[AW-1:0]), .rdata(head_word)
  );

  assign rd_data = out_en_n ? {DW{1'bz}} : head_word;

endmodule

// File: rtl/fifo_thr_checks.sv
module fifo_thr_checks
  import fifo_thr_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full_n,
  input logic          empty_n,
  input logic          half_full,
  input logic          near_edge,
  input logic          prog_edge,
  input logic [AW:0]   wr_ptr,
  input logic [AW:0]   wr_gray,
  input logic [AW:0]   rd_ptr,
  input logic [AW:0]   rd_gray,
  input logic [AW-1:0] thr_lo,
  input logic [AW-1:0] thr_hi,
  input prog_win_e     win
);

  localparam logic [AW-1:0] OFF_MAX = AW'((1 << AW) / 2 - 1);

  assert_no_overflow_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && wr_en) |=> $stable(wr_ptr));

  assert_no_underflow_R1: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && rd_en) |=> $stable(rd_ptr));

  assert_wgray_step_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  assert_rgray_step_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

  assert_full_sets_upper_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> (half_full && near_edge));

  assert_prog_no_store_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    prog_edge |=> $stable(wr_ptr));

  assert_thr_limit_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (thr_lo <= OFF_MAX) && (thr_hi <= OFF_MAX));

  assert_window_stays_closed_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (win == PW_CLOSED) |=> (win == PW_CLOSED) && $stable(thr_lo) && $stable(thr_hi));

endmodule

bind dcfifo_thresh fifo_thr_checks #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
  .rd_en(rd_en), .full_n(full_n), .empty_n(empty_n), .half_full(half_full),
  .near_edge(near_edge), .prog_edge(prog_edge), .wr_ptr(wr_ptr),
  .wr_gray(wr_gray), .rd_ptr(rd_ptr), .rd_gray(rd_gray), .thr_lo(thr_lo),
  .thr_hi(thr_hi), .win(win)
);

// File: tb/dcfifo_thresh_tb.sv
module dcfifo_thresh_tb;

  localparam int DW    = 18;
  localparam int DEPTH = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          prog_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] rd_data;
  logic          full_n, empty_n, half_full, near_edge;

  always #10 clk = ~clk;

  dcfifo_thresh u_dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .prog_n(prog_n), .wr_data(wr_data), .rd_en(rd_en), .out_en_n(out_en_n),
    .rd_data(rd_data), .full_n(full_n), .empty_n(empty_n),
    .half_full(half_full), .near_edge(near_edge)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [DW-1:0] sb_q[$];
  int lo_m, hi_m, win_m;
  int seq = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int clamp127(input logic [7:0] v);
    return (v > 8'd127) ? 127 : int'(v);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    sb_q.delete();
    lo_m = 32; hi_m = 32; win_m = 0;
    @(negedge clk);
  endtask

  // Driver: one write edge, scoreboard updated from the requirements
  task automatic do_write(input logic [DW-1:0] d);
    @(negedge clk);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (win_m != 2 && !prog_n) begin
      if (win_m == 0) begin lo_m = clamp127(d[7:0]); hi_m = lo_m; win_m = 1; end
      else begin hi_m = clamp127(d[7:0]); win_m = 2; end
    end else begin
      win_m = 2;
      if (sb_q.size() < DEPTH) sb_q.push_back(d);
    end
  endtask

  // Monitor: compare the presented word, then take it
  task automatic do_read(input string req);
    @(negedge clk);
    if (sb_q.size() > 0) check(req, "head word", 32'(rd_data), 32'(sb_q[0]));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (sb_q.size() > 0) void'(sb_q.pop_front());
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_flags(input string req);
    int n;
    settle();
    n = sb_q.size();
    check(req, "full_n",    32'(full_n),    32'(n != DEPTH));
    check(req, "empty_n",   32'(empty_n),   32'(n != 0));
    check(req, "half_full", 32'(half_full), 32'(n >= DEPTH / 2));
    check(req, "near_edge", 32'(near_edge), 32'((n <= lo_m) || (n >= DEPTH - hi_m)));
  endtask

  task automatic fill_to(input int target, input string req);
    while (sb_q.size() < target) begin
      seq++;
      do_write(DW'(seq * 32'h0137) ^ 18'h2A5A5);
    end
    check_flags(req);
  endtask

  task automatic drain(input string req);
    settle();
    while (sb_q.size() > 0) do_read(req);
    check_flags(req);
  endtask

  initial begin
    lo_m = 32; hi_m = 32; win_m = 0;
    do_reset();
    // R5: reset state
    check("R5", "full_n after reset",    32'(full_n),    32'd1);
    check("R5", "empty_n after reset",   32'(empty_n),   32'd0);
    check("R5", "half_full after reset", 32'(half_full), 32'd0);
    check("R5", "near_edge after reset", 32'(near_edge), 32'd1);

    // Default thresholds, first word falls through (R9, R7)
    prog_n = 1'b1;
    do_write(18'h3C0DE);
    settle();
    check("R9", "fall-through word", 32'(rd_data), 32'h3C0DE);
    check("R9", "empty_n with one word", 32'(empty_n), 32'd1);
    out_en_n = 1'b1; #1;
    check("R10", "high impedance", 32'(rd_data === {DW{1'bz}}), 32'd1);
    out_en_n = 1'b0;
    fill_to(32, "R7");
    fill_to(33, "R4");
    fill_to(127, "R3");
    fill_to(128, "R3");
    fill_to(223, "R4");
    fill_to(224, "R4");
    fill_to(255, "R2");
    fill_to(256, "R2");
    do_write(18'h00BAD);             // R1: refused while full
    check_flags("R1");
    drain("R1");
    do_read("R1");                    // read while empty: no effect
    do_write(18'h1F00F);
    settle();
    check("R1", "word after empty read", 32'(rd_data), 32'h1F00F);
    drain("R1");

    // Two loading edges: LO=HI=10, then HI=200 taken as 127 (R6, R7)
    do_reset();
    prog_n = 1'b0;
    do_write(18'h0000A);
    do_write(18'h000C8);
    prog_n = 1'b1;
    check_flags("R6");
    fill_to(10, "R6");
    fill_to(11, "R6");
    fill_to(128, "R7");
    fill_to(129, "R7");
    drain("R6");

    // One loading edge, then window closes (R8)
    do_reset();
    prog_n = 1'b0;
    do_write(18'h00005);
    prog_n = 1'b1;
    do_write(18'h2AAAA);
    prog_n = 1'b0;
    do_write(18'h15555);
    prog_n = 1'b1;
    settle();
    check("R8", "first stored word", 32'(rd_data), 32'h2AAAA);
    check_flags("R8");
    fill_to(5, "R8");
    fill_to(6, "R8");
    fill_to(250, "R8");
    fill_to(251, "R8");
    drain("R8");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule